// File: doc/BRIEF.md
# Programmable Event Counter

This block is a single programmable hardware performance counter for a processor core. Each cycle it may receive an increment strobe for the event it tracks. It adds one to its count only when counting is allowed for the present privilege level and virtualization state, and only when the counter is not inhibited. An increment that carries the count past its maximum wraps it to zero and sets a sticky overflow flag. When that flag goes from clear to set, the block raises a counter-overflow interrupt request and holds it until the request is acknowledged.

The count and the event-control word are 64 bits wide. Software reaches them through a small register port. In 64-bit mode each one is a single word. In 32-bit mode each one is split into a low register and a high register, and the high control register carries the filter bits and the overflow flag. The counter's index is fixed by parameters. Indices 0 to 2 belong to fixed counters that live elsewhere, so the first programmable index is 3.

Top module: `prog_event_counter`

## Requirements
- R1: After a synchronous active-low reset, the count, the control word and the interrupt request are all zero.
- R2: No increment takes effect while `cinh_i` is high. No increment ever takes effect when the counter's index `CTR_IDX` is outside the configured range [3, 3+`NUM_PROG_CTRS`). When `NUM_PROG_CTRS` is 0, that range is empty.
- R3: Privilege is encoded U=0, S=1, M=3, and 2 is treated as unfiltered. Control bit 62 inhibits counting in M. Bit 61 inhibits S with virtualization off and bit 60 inhibits U with virtualization off. Bit 59 inhibits S with virtualization on and bit 58 inhibits U with virtualization on. The `virt_i` input is ignored in M.
- R4: In 64-bit mode (`mode32_i`=0), an increment from all ones wraps the 64-bit count to zero. Any other increment adds one.
- R5: On a wrap, control bit 63 (the overflow flag) is set. `irq_o` rises only if that flag was clear before the wrap. If the flag was already set, the wrap leaves `irq_o` unchanged.
- R6: The overflow flag stays set until software writes a zero to it. `irq_o` stays high until `irq_ack_i` is seen, and the acknowledge does not touch the flag.
- R7: A register write in the same cycle as an increment strobe takes effect, and that increment is dropped.
- R8: In 32-bit mode, an increment adds one to the low half unless the low half is all ones. In that case the high half adds one and the low half keeps its value.
- R9: In 32-bit mode, an increment with both halves all ones sets both halves to zero and applies R5. The overflow flag is then bit 31 of the high control register, and the filter bits are its bits 30 to 26.
- R10: Register addresses are 0 = count (low half in 32-bit mode), 1 = count high half, 2 = control (low half in 32-bit mode), 3 = control high half. A 32-bit access uses data bits 31:0, and bits 63:32 of the read data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inc_i | input | 1 | Event increment strobe |
| priv_i | input | 2 | Current privilege level (U=0, S=1, M=3) |
| virt_i | input | 1 | Virtualization active |
| cinh_i | input | 1 | This counter's counter-inhibit bit |
| mode32_i | input | 1 | 1 selects split 32-bit register view |
| we_i | input | 1 | Register write enable |
| addr_i | input | 2 | Register address |
| wdata_i | input | 64 | Register write data |
| rdata_o | output | 64 | Register read data |
| irq_ack_i | input | 1 | Acknowledge of the overflow interrupt request |
| irq_o | output | 1 | Counter-overflow interrupt request |

## Verification
The assertions watch four things on every cycle: that an inhibited counter holds its value, the 64-bit wrap, holding the low half during a 32-bit high-half carry, and write priority for full-width count writes. They also check that the overflow flag stays sticky and that the interrupt rises only together with that flag and stays up until acknowledged. The five-way privilege and virtualization filter is covered only by the bench's vector walk, and so are the disabled-index variant and the register map in both modes. The case where a second wrap raises no new request is likewise covered only by those scenarios.

// File: rtl/pctr_pkg.sv
// Shared types and field positions for the programmable event counter.
// Assumes a 64-bit count and control word. Field positions are fixed so that
// the high 32-bit control register carries them at the same place.
package pctr_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        RA_CNT    = 2'd0,
        RA_CNT_HI = 2'd1,
        RA_CTL    = 2'd2,
        RA_CTL_HI = 2'd3
    } raddr_e;

    // Per-mode inhibit bits taken from the control word.
    typedef struct packed {
        logic m;
        logic s;
        logic u;
        logic vs;
        logic vu;
    } inh_t;

    localparam int unsigned HALF_W  = 32;
    localparam int unsigned CNT_W   = 2 * HALF_W;
    localparam int unsigned OVF_BIT = CNT_W - 1;     // overflow flag
    localparam int unsigned INH_HI  = CNT_W - 2;     // top of inhibit field
    localparam int unsigned INH_LO  = CNT_W - 6;     // bottom of inhibit field

endpackage

// File: rtl/pctr_filter.sv
// Decides whether an increment may count this cycle.
// Assumes the inhibit bits are already extracted from the control word.
// When the counter's index is unconfigured, the variant that never counts is
// chosen at elaboration time.
module pctr_filter
    import pctr_pkg::*;
#(
    parameter bit USABLE = 1'b1
) (
    input  priv_e priv_i,
    input  logic  virt_i,
    input  logic  cinh_i,
    input  inh_t  inh_i,
    output logic  allow_o
);

    generate
        if (USABLE) begin : g_live
            logic blocked;

            // Select the inhibit bit that applies to the current mode.
            always_comb begin
                case (priv_i)
                    PRIV_M:  blocked = inh_i.m;
                    PRIV_S:  blocked = virt_i ? inh_i.vs : inh_i.s;
                    PRIV_U:  blocked = virt_i ? inh_i.vu : inh_i.u;
                    default: blocked = 1'b0;
                endcase
            end

            assign allow_o = !cinh_i && !blocked;
        end else begin : g_dead
            logic unused_in;
            assign unused_in = ^{priv_i, virt_i, cinh_i, inh_i};
            assign allow_o   = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/pctr_count.sv
// Count register with write port and both wrap disciplines.
// Assumes step_i is never high in a cycle that carries a write.
// The 64-bit view carries from the low half into the high half. The split
// view bumps only the high half once the low half is saturated.
module pctr_count
    import pctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             mode32_i,
    input  logic             wr_full_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    logic [CNT_W-1:0]  cnt_q;
    logic [HALF_W-1:0] lo, hi;
    logic              lo_max, all_max;

    assign lo      = cnt_q[HALF_W-1:0];
    assign hi      = cnt_q[CNT_W-1:HALF_W];
    assign lo_max  = &lo;
    assign all_max = &cnt_q;
    assign wrap_o  = step_i && all_max;
    assign cnt_o   = cnt_q;

    // Apply software writes first, otherwise advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_full_i) begin
            cnt_q <= wdata_i;
        end else if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) cnt_q[HALF_W-1:0]     <= wdata_i[HALF_W-1:0];
            if (wr_hi_i) cnt_q[CNT_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
        end else if (step_i) begin
            if (all_max)
                cnt_q <= '0;
            else if (mode32_i && lo_max)
                cnt_q[CNT_W-1:HALF_W] <= hi + 1'b1;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4
    wrap64_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !mode32_i && all_max) |=> (cnt_q == '0));

    // R8
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode32_i && lo_max && !(&hi)) |=>
        (&cnt_q[HALF_W-1:0]) && (cnt_q[CNT_W-1:HALF_W] == $past(hi) + 1'b1));

    // R7
    wr_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full_i |=> (cnt_q == $past(wdata_i)));

endmodule

// File: rtl/pctr_ctl.sv
// Event-control register, sticky overflow flag and interrupt request.
// Assumes wrap_i is only raised in cycles without a register write.
// Software clears the flag by writing it to zero. The request is cleared only
// by the acknowledge.
module pctr_ctl
    import pctr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_full_i,
    input  logic             wr_lo_i,
    input  logic             wr_hi_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             wrap_i,
    input  logic             ack_i,
    output logic [CNT_W-1:0] ctl_o,
    output logic             irq_o
);

    logic [CNT_W-1:0] ctl_q;
    logic             irq_q;
    logic             of;
    logic             raise;

    assign of    = ctl_q[OVF_BIT];
    assign raise = wrap_i && !of;
    assign ctl_o = ctl_q;
    assign irq_o = irq_q;

    // Hold the control word: writes, then the overflow flag on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_full_i) begin
            ctl_q <= wdata_i;
        end else if (wr_lo_i || wr_hi_i) begin
            if (wr_lo_i) ctl_q[HALF_W-1:0]     <= wdata_i[HALF_W-1:0];
            if (wr_hi_i) ctl_q[CNT_W-1:HALF_W] <= wdata_i[HALF_W-1:0];
        end else if (raise) begin
            ctl_q[OVF_BIT] <= 1'b1;
        end
    end

    // Keep the interrupt request pending from a new overflow until acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_q <= 1'b0;
        else if (raise) irq_q <= 1'b1;
        else if (ack_i) irq_q <= 1'b0;
    end

    // R6
    of_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (of && !wr_full_i && !wr_hi_i) |=> of);

    // R5
    irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $rose(of));

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !ack_i) |=> irq_q);

endmodule

// File: rtl/prog_event_counter.sv
// One programmable performance counter with mode filtering and overflow.
// Assumes CTR_IDX and NUM_PROG_CTRS are fixed at integration. Indices below 3
// are reserved for the fixed counters. Decodes the register port and gates the
// increment strobe.
module prog_event_counter
    import pctr_pkg::*;
#(
    parameter int unsigned CTR_IDX       = 3,
    parameter int unsigned NUM_PROG_CTRS = 29
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   inc_i,
    input  logic [1:0]             priv_i,
    input  logic                   virt_i,
    input  logic                   cinh_i,
    input  logic                   mode32_i,
    input  logic                   we_i,
    input  logic [1:0]             addr_i,
    input  logic [2*HALF_W-1:0]    wdata_i,
    output logic [2*HALF_W-1:0]    rdata_o,
    input  logic                   irq_ack_i,
    output logic                   irq_o
);

    localparam int unsigned FIRST_IDX = 3;
    localparam bit USABLE = (CTR_IDX >= FIRST_IDX) &&
                            (CTR_IDX < FIRST_IDX + NUM_PROG_CTRS);

    raddr_e           ra;
    logic [CNT_W-1:0] cnt, ctl;
    logic             allow, step, wrap;
    logic             cw_full, cw_lo, cw_hi, kw_full, kw_lo, kw_hi;
    inh_t             inh;

    assign ra  = raddr_e'(addr_i);
    assign inh = inh_t'(ctl[INH_HI:INH_LO]);

    // Decode writes: the count and control halves depend on the mode.
    always_comb begin
        cw_full = we_i && (ra == RA_CNT) && !mode32_i;
        cw_lo   = we_i && (ra == RA_CNT) &&  mode32_i;
        cw_hi   = we_i && (ra == RA_CNT_HI);
        kw_full = we_i && (ra == RA_CTL) && !mode32_i;
        kw_lo   = we_i && (ra == RA_CTL) &&  mode32_i;
        kw_hi   = we_i && (ra == RA_CTL_HI);
    end

    // A write in the same cycle wins over the increment.
    assign step = inc_i && allow && !we_i;

    pctr_filter #(.USABLE(USABLE)) u_filter (
        .priv_i  (priv_e'(priv_i)),
        .virt_i  (virt_i),
        .cinh_i  (cinh_i),
        .inh_i   (inh),
        .allow_o (allow)
    );

    pctr_count u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .mode32_i  (mode32_i),
        .wr_full_i (cw_full),
        .wr_lo_i   (cw_lo),
        .wr_hi_i   (cw_hi),
        .wdata_i   (wdata_i),
        .cnt_o     (cnt),
        .wrap_o    (wrap)
    );

    pctr_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_full_i (kw_full),
        .wr_lo_i   (kw_lo),
        .wr_hi_i   (kw_hi),
        .wdata_i   (wdata_i),
        .wrap_i    (wrap),
        .ack_i     (irq_ack_i),
        .ctl_o     (ctl),
        .irq_o     (irq_o)
    );

    // Read mux: 32-bit views zero the upper half of the read data.
    always_comb begin
        case (ra)
            RA_CNT:    rdata_o = mode32_i ? {{HALF_W{1'b0}}, cnt[HALF_W-1:0]} : cnt;
            RA_CNT_HI: rdata_o = {{HALF_W{1'b0}}, cnt[CNT_W-1:HALF_W]};
            RA_CTL:    rdata_o = mode32_i ? {{HALF_W{1'b0}}, ctl[HALF_W-1:0]} : ctl;
            default:   rdata_o = {{HALF_W{1'b0}}, ctl[CNT_W-1:HALF_W]};
        endcase
    end

    // R2
    inhibit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cinh_i && !we_i) |=> $stable(cnt));

endmodule

// File: tb/prog_event_counter_test.sv
module prog_event_counter_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] ONES = '1;

    // Vector: [9:8] priv, [7] virt, [6:2] inhibit {M,S,U,VS,VU}, [1] cinh, [0] expect count
    localparam int NVEC = 12;
    localparam logic [9:0] VEC [NVEC] = '{
        {2'd3, 1'b0, 5'b00000, 1'b0, 1'b1},
        {2'd3, 1'b0, 5'b10000, 1'b0, 1'b0},
        {2'd3, 1'b1, 5'b01111, 1'b0, 1'b1},
        {2'd1, 1'b0, 5'b01000, 1'b0, 1'b0},
        {2'd1, 1'b0, 5'b00010, 1'b0, 1'b1},
        {2'd1, 1'b1, 5'b00010, 1'b0, 1'b0},
        {2'd1, 1'b1, 5'b01000, 1'b0, 1'b1},
        {2'd0, 1'b0, 5'b00100, 1'b0, 1'b0},
        {2'd0, 1'b0, 5'b00001, 1'b0, 1'b1},
        {2'd0, 1'b1, 5'b00001, 1'b0, 1'b0},
        {2'd0, 1'b1, 5'b00100, 1'b0, 1'b1},
        {2'd3, 1'b0, 5'b00000, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc = 1'b0;
    logic [1:0]  priv = 2'd3;
    logic        virt = 1'b0;
    logic        cinh = 1'b0;
    logic        mode32 = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata, rdata_off;
    logic        ack = 1'b0;
    logic        irq, irq_off;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_event_counter #(.CTR_IDX(3), .NUM_PROG_CTRS(4)) uut (
        .clk(clk), .rst_n(rst_n), .inc_i(inc), .priv_i(priv), .virt_i(virt),
        .cinh_i(cinh), .mode32_i(mode32), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .irq_ack_i(ack), .irq_o(irq)
    );

    // Index left unconfigured: never counts (R2).
    prog_event_counter #(.CTR_IDX(3), .NUM_PROG_CTRS(0)) uut_off (
        .clk(clk), .rst_n(rst_n), .inc_i(inc), .priv_i(priv), .virt_i(virt),
        .cinh_i(1'b0), .mode32_i(1'b0), .we_i(1'b0), .addr_i(2'd0),
        .wdata_i(64'd0), .rdata_o(rdata_off), .irq_ack_i(1'b0), .irq_o(irq_off)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        we = 1'b1; addr = a; wdata = d;
        cyc();
        we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic bump();
        inc = 1'b1;
        cyc();
        inc = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] v;
        repeat (3) cyc();
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); check(v == 64'd0, "R1 count", v, 64'd0);
        rd(2'd2, v); check(v == 64'd0, "R1 control", v, 64'd0);
        check(irq == 1'b0, "R1 irq", {63'd0, irq}, 64'd0);

        // R3 / R2 filter vector walk in 64-bit mode
        for (int i = 0; i < NVEC; i++) begin
            priv = VEC[i][9:8];
            virt = VEC[i][7];
            cinh = VEC[i][1];
            wr(2'd2, {1'b0, VEC[i][6:2], 58'd0});
            wr(2'd0, 64'd0);
            bump();
            rd(2'd0, v);
            check(v == {63'd0, VEC[i][0]}, "R3/R2 filter vector", v, {63'd0, VEC[i][0]});
        end
        priv = 2'd3; virt = 1'b0; cinh = 1'b0;
        wr(2'd2, 64'd0);

        // R4 / R5 64-bit wrap raises overflow and request
        wr(2'd0, ONES);
        bump();
        rd(2'd0, v); check(v == 64'd0, "R4 wrap to zero", v, 64'd0);
        rd(2'd2, v); check(v[63] == 1'b1, "R5 overflow flag set", {63'd0, v[63]}, 64'd1);
        check(irq == 1'b1, "R5 irq raised", {63'd0, irq}, 64'd1);

        // R6 request held until acknowledged, flag untouched by ack
        repeat (3) cyc();
        check(irq == 1'b1, "R6 irq held", {63'd0, irq}, 64'd1);
        ack = 1'b1; cyc(); ack = 1'b0;
        check(irq == 1'b0, "R6 irq cleared by ack", {63'd0, irq}, 64'd0);
        rd(2'd2, v); check(v[63] == 1'b1, "R6 flag sticky after ack", {63'd0, v[63]}, 64'd1);

        // R5 second wrap with flag already set: no new request
        wr(2'd0, ONES);
        bump();
        rd(2'd0, v); check(v == 64'd0, "R4 second wrap", v, 64'd0);
        check(irq == 1'b0, "R5 no request when flag set", {63'd0, irq}, 64'd0);

        // R6 clearing the flag by write re-arms the request
        wr(2'd2, 64'd0);
        rd(2'd2, v); check(v[63] == 1'b0, "R6 flag cleared by write", {63'd0, v[63]}, 64'd0);
        wr(2'd0, ONES);
        bump();
        check(irq == 1'b1, "R5 request after re-arm", {63'd0, irq}, 64'd1);
        ack = 1'b1; cyc(); ack = 1'b0;
        wr(2'd2, 64'd0);

        // R7 write beats a simultaneous increment
        inc = 1'b1;
        wr(2'd0, 64'd5);
        rd(2'd0, v); check(v == 64'd5, "R7 write wins over increment", v, 64'd5);
        cyc();
        inc = 1'b0;
        rd(2'd0, v); check(v == 64'd6, "R7 count resumes", v, 64'd6);

        // R8 / R9 / R10 split 32-bit view
        mode32 = 1'b1;
        wr(2'd3, 64'd0);
        wr(2'd0, 64'h0000_0000_FFFF_FFFE);
        wr(2'd1, 64'd0);
        bump();
        rd(2'd0, v); check(v == 64'h0000_0000_FFFF_FFFF, "R8 low advances", v, 64'h0000_0000_FFFF_FFFF);
        bump();
        rd(2'd0, v); check(v == 64'h0000_0000_FFFF_FFFF, "R8 low held at max", v, 64'h0000_0000_FFFF_FFFF);
        rd(2'd1, v); check(v == 64'd1, "R8 high advances", v, 64'd1);
        wr(2'd1, 64'h0000_0000_FFFF_FFFF);
        bump();
        rd(2'd0, v); check(v == 64'd0, "R9 low wraps", v, 64'd0);
        rd(2'd1, v); check(v == 64'd0, "R9 high wraps", v, 64'd0);
        rd(2'd3, v); check(v == 64'h0000_0000_8000_0000, "R9 flag in high control", v, 64'h0000_0000_8000_0000);
        check(irq == 1'b1, "R9 request in 32-bit mode", {63'd0, irq}, 64'd1);
        ack = 1'b1; cyc(); ack = 1'b0;

        // R9 / R10 filter bits read from high control half
        wr(2'd3, 64'h0000_0000_4000_0000);
        wr(2'd2, 64'h0000_0000_FFFF_FFFF);
        bump();
        rd(2'd0, v); check(v == 64'd0, "R9 M inhibit from high half", v, 64'd0);
        rd(2'd2, v); check(v == 64'h0000_0000_FFFF_FFFF, "R10 low control readback", v, 64'h0000_0000_FFFF_FFFF);
        wr(2'd3, 64'd0);
        bump();
        rd(2'd0, v); check(v == 64'd1, "R9 counts once uninhibited", v, 64'd1);

        // R2 unconfigured counter never moved
        check(rdata_off == 64'd0, "R2 unconfigured index idle", rdata_off, 64'd0);
        check(irq_off == 1'b0, "R2 unconfigured no request", {63'd0, irq_off}, 64'd0);

        finish_run();
    end

endmodule